// File: doc/BRIEF.md
# Multi-Core Doorbell Event Fabric

This block links a set of identical doorbell nodes, one per processor core, through a shared set of broadcast lines. Each node owns a configurable number of local channels. When software (or a pulse from an outside event network) fires a send on a local channel, the node drives every broadcast line selected by that channel's transmit mask. In the same cycle, every node, the sender included, compares the active broadcast lines with each local channel's listen mask and latches a doorbell flag on every channel that matches. One send can therefore ring several channels in several nodes at once.

Each node carries its own register file. It holds send triggers, transmit and listen masks, doorbell flags, an interrupt enable register with bit-set and bit-clear aliases, a read-only pending view and a sticky error flag. It drives one level interrupt and a per-channel one-cycle notification pulse. All nodes share a single write port, steered by a node select input, and a combinational read port.

Top module: `ipc_fabric`

## Requirements
- R1: After reset every register of every node reads zero, every interrupt output is low and no notification pulse is active.
- R2: Address field `addr[7:5]` selects the register kind (0 send trigger, 1 transmit mask, 2 listen mask, 3 doorbell flag, 4 control) and `addr[4:0]` the channel. A write of nonzero data to kind 0 fires a send on that channel. A write of zero fires nothing, and kind 0 always reads zero.
- R3: A send on local channel c drives every broadcast line whose bit is set in the transmit mask of c. Sends from all nodes in the same cycle are ORed onto the lines.
- R4: On the clock edge that samples a send, every channel i of every node whose listen mask shares a bit with the active lines sets its doorbell flag i.
- R5: Control select 3 reads pending = enable AND doorbell flags. The node's interrupt output is high exactly when pending is nonzero, and it follows any flag or enable change by the next edge.
- R6: Each time a doorbell flag is set by a send, the notification pulse of that channel (bit node*N_CH+channel of `evt_pulse_o`) is high for exactly one cycle, even if the flag was already set.
- R7: A one-cycle high on `send_pulse_i` bit node*N_CH+c fires the same send as a nonzero write to that node's send trigger c.
- R8: Sends on consecutive cycles are not merged: each produces its own notification pulse.
- R9: Control select 0 writes the enable register directly. Select 1 sets and select 2 clears each enable bit written as 1. Selects 0 to 2 read back the enable register.
- R10: Writing zero to a doorbell flag clears it, and writing nonzero leaves it unchanged. A send that sets the flag in the same cycle as a clear wins.
- R11: A write to kinds 0 to 3 with a channel at or above N_CH changes nothing and sets the error flag (control select 4). Only reset clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Node select for write and read |
| reg_addr | input | 8 | Register kind and channel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected node (combinational) |
| send_pulse_i | input | N_INST*N_CH | Per-channel send pulses from an outside event network |
| evt_pulse_o | output | N_INST*N_CH | Per-channel doorbell notification pulses |
| irq_o | output | N_INST | Level interrupt per node |

## Verification
Every result of a send is due on the first rising edge that samples it. The doorbell flags, pending bits and interrupt change there. The notification pulse is high from that edge to the next and is low one cycle later. The bench drives inputs on falling edges and samples pulses on the following falling edge, exactly one edge after the stimulus. The second falling edge confirms the pulse has dropped. Reads are combinational, so register values are taken a delta after the address settles, between edges.

// File: rtl/ipc_fabric_pkg.sv
package ipc_fabric_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CHAN_W = 5;

    typedef enum logic [2:0] {
        K_SEND  = 3'd0,
        K_TMASK = 3'd1,
        K_LMASK = 3'd2,
        K_FLAG  = 3'd3,
        K_CTRL  = 3'd4
    } reg_kind_e;

    typedef enum logic [4:0] {
        C_EN    = 5'd0,
        C_ENSET = 5'd1,
        C_ENCLR = 5'd2,
        C_PEND  = 5'd3,
        C_ERR   = 5'd4
    } ctrl_sel_e;

endpackage

// File: rtl/ipc_regdec.sv
module ipc_regdec
    import ipc_fabric_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_CH-1:0]   sub_i,
    output reg_kind_e         kind,
    output ctrl_sel_e         csel,
    output logic [N_CH-1:0]   chan_sel,
    output logic [N_CH-1:0]   chan_wr,
    output logic [N_CH-1:0]   trig,
    output logic              data_zero,
    output logic              bad_wr
);

    logic [CHAN_W-1:0] chan;
    logic              chan_kind;
    logic              chan_ok;

    always_comb begin
        kind      = reg_kind_e'(addr[7:5]);
        chan      = addr[4:0];
        csel      = ctrl_sel_e'(chan);
        data_zero = (wdata == '0);
        chan_kind = (addr[7:5] <= 3'd3);
        chan_ok   = (32'(chan) < N_CH);
        bad_wr    = wr_en && chan_kind && !chan_ok;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        always_comb begin
            chan_sel[c] = (chan == CHAN_W'(c));
            chan_wr[c]  = wr_en && chan_sel[c];
            trig[c]     = sub_i[c] || (chan_wr[c] && kind == K_SEND && !data_zero);
        end
    end

endmodule

// File: rtl/ipc_backbone.sv
module ipc_backbone #(
    parameter int N_INST = 2,
    parameter int BB_W   = 8
) (
    input  logic [N_INST-1:0][BB_W-1:0] send_i,
    output logic [BB_W-1:0]             line_o
);

    always_comb begin
        line_o = '0;
        for (int k = 0; k < N_INST; k++) begin
            line_o = line_o | send_i[k];
        end
    end

endmodule

// File: rtl/ipc_node.sv
module ipc_node
    import ipc_fabric_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int BB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_CH-1:0]   sub_i,
    input  logic [BB_W-1:0]   line_i,
    output logic [BB_W-1:0]   send_o,
    output logic [N_CH-1:0]   pulse_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [N_CH-1:0][BB_W-1:0] tmask;
        logic [N_CH-1:0][BB_W-1:0] lmask;
        logic [N_CH-1:0]           flag;
        logic [N_CH-1:0]           en;
        logic [N_CH-1:0]           pulse;
        logic                      err;
    } node_st_t;

    node_st_t st_d, st_q;

    reg_kind_e       kind;
    ctrl_sel_e       csel;
    logic [N_CH-1:0] chan_sel;
    logic [N_CH-1:0] chan_wr;
    logic [N_CH-1:0] trig;
    logic            data_zero;
    logic            bad_wr;
    logic [N_CH-1:0] hit;
    logic [N_CH-1:0] pend;

    ipc_regdec #(.N_CH(N_CH)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .sub_i     (sub_i),
        .kind      (kind),
        .csel      (csel),
        .chan_sel  (chan_sel),
        .chan_wr   (chan_wr),
        .trig      (trig),
        .data_zero (data_zero),
        .bad_wr    (bad_wr)
    );

    // outgoing broadcast lines
    always_comb begin
        send_o = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (trig[c]) send_o = send_o | st_q.tmask[c];
        end
    end

    // listen match against the shared lines
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            hit[i] = |(st_q.lmask[i] & line_i);
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = hit;
        for (int i = 0; i < N_CH; i++) begin
            if (chan_wr[i]) begin
                case (kind)
                    K_TMASK: st_d.tmask[i] = wdata[BB_W-1:0];
                    K_LMASK: st_d.lmask[i] = wdata[BB_W-1:0];
                    K_FLAG:  if (data_zero) st_d.flag[i] = 1'b0;
                    default: ;
                endcase
            end
        end
        st_d.flag = st_d.flag | hit;
        if (wr_en && kind == K_CTRL) begin
            case (csel)
                C_EN:    st_d.en = wdata[N_CH-1:0];
                C_ENSET: st_d.en = st_q.en | wdata[N_CH-1:0];
                C_ENCLR: st_d.en = st_q.en & ~wdata[N_CH-1:0];
                default: ;
            endcase
        end
        if (bad_wr) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pend    = st_q.en & st_q.flag;
        irq_o   = |pend;
        pulse_o = st_q.pulse;
    end

    always_comb begin
        rdata = '0;
        if (kind == K_CTRL) begin
            case (csel)
                C_EN, C_ENSET, C_ENCLR: rdata[N_CH-1:0] = st_q.en;
                C_PEND:                 rdata[N_CH-1:0] = pend;
                C_ERR:                  rdata[0]        = st_q.err;
                default: ;
            endcase
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                if (chan_sel[c]) begin
                    case (kind)
                        K_TMASK: rdata[BB_W-1:0] = st_q.tmask[c];
                        K_LMASK: rdata[BB_W-1:0] = st_q.lmask[c];
                        K_FLAG:  rdata[0]        = st_q.flag[c];
                        default: ;
                    endcase
                end
            end
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R4: a listen match is latched as a doorbell flag
        a_r4_flag_set : assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> st_q.flag[i]);
        // R6: a notification pulse only accompanies a set flag
        a_r6_pulse_flag : assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[i] |-> st_q.flag[i]);
        // R10: a zero write with no competing send clears the flag
        a_r10_clear : assert property (@(posedge clk) disable iff (!rst_n)
            (chan_wr[i] && kind == K_FLAG && data_zero && !hit[i]) |=> !st_q.flag[i]);
    end

    // R11: the error flag is sticky
    a_r11_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    // R11: an out-of-range write leaves the masks untouched
    a_r11_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> ($stable(st_q.tmask) && $stable(st_q.lmask)));
    // R5: with nothing enabled the interrupt stays low
    a_r5_no_irq : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_o);

endmodule

// File: rtl/ipc_fabric.sv
module ipc_fabric
    import ipc_fabric_pkg::*;
#(
    parameter int N_INST = 2,
    parameter int N_CH   = 4,
    parameter int BB_W   = 8,
    localparam int SEL_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [N_INST*N_CH-1:0] send_pulse_i,
    output logic [N_INST*N_CH-1:0] evt_pulse_o,
    output logic [N_INST-1:0]      irq_o
);

    logic [N_INST-1:0][BB_W-1:0]   node_send;
    logic [BB_W-1:0]               lines;
    logic [N_INST-1:0][DATA_W-1:0] node_rd;

    ipc_backbone #(.N_INST(N_INST), .BB_W(BB_W)) u_bb (
        .send_i (node_send),
        .line_o (lines)
    );

    for (genvar k = 0; k < N_INST; k++) begin : g_node
        ipc_node #(.N_CH(N_CH), .BB_W(BB_W)) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && reg_sel == SEL_W'(k)),
            .addr    (reg_addr),
            .wdata   (reg_wdata),
            .rdata   (node_rd[k]),
            .sub_i   (send_pulse_i[k*N_CH +: N_CH]),
            .line_i  (lines),
            .send_o  (node_send[k]),
            .pulse_o (evt_pulse_o[k*N_CH +: N_CH]),
            .irq_o   (irq_o[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_INST; k++) begin
            if (reg_sel == SEL_W'(k)) reg_rdata = node_rd[k];
        end
    end

endmodule

// File: tb/ipc_fabric_bench.sv
`timescale 1ns/1ps
module ipc_fabric_bench;

    localparam int NI = 2;
    localparam int NC = 4;
    localparam int BW = 8;
    localparam int NP = NI * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [0:0]    reg_sel = '0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] send_pulse_i = '0;
    logic [NP-1:0] evt_pulse_o;
    logic [NI-1:0] irq_o;

    always #5 clk = ~clk;

    ipc_fabric #(.N_INST(NI), .N_CH(NC), .BB_W(BW)) u_ipc_fabric (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .send_pulse_i(send_pulse_i), .evt_pulse_o(evt_pulse_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [BW-1:0] tm [NI][NC];
    logic [BW-1:0] lm [NI][NC];
    logic [NC-1:0] en [NI];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ad(input int kind, input int ch);
        return 8'(kind * 32 + ch);
    endfunction

    task automatic wr(input int s, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'(s); reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int s, input logic [7:0] a, output logic [31:0] v);
        reg_sel = 1'(s); reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [NP-1:0] expect_hits(input logic [BW-1:0] lines);
        logic [NP-1:0] e;
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NC; i++)
                e[k*NC+i] = |(lm[k][i] & lines);
        return e;
    endfunction

    // fire a send; p1 sampled one edge later, p2 one cycle after that
    task automatic fire(input int s, input int c, input bit use_sub,
                        output logic [NP-1:0] p1, output logic [NP-1:0] p2);
        @(negedge clk);
        if (use_sub) send_pulse_i[s*NC+c] = 1'b1;
        else begin
            reg_wr = 1'b1; reg_sel = 1'(s); reg_addr = ad(0, c); reg_wdata = 32'h1;
        end
        @(negedge clk);
        p1 = evt_pulse_o;
        send_pulse_i = '0; reg_wr = 1'b0;
        @(negedge clk);
        p2 = evt_pulse_o;
    endtask

    task automatic clear_all();
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NC; i++)
                wr(k, ad(3, i), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NP-1:0] p1, p2, e;
        logic [NC-1:0] ek;
        int fk, fi;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset
        for (int k = 0; k < NI; k++) begin
            for (int kind = 0; kind < 4; kind++)
                for (int i = 0; i < NC; i++) begin
                    rd(k, ad(kind, i), v);
                    check("R1 register", v, 32'h0);
                end
            for (int cs = 0; cs < 5; cs++) begin
                rd(k, ad(4, cs), v);
                check("R1 control", v, 32'h0);
            end
        end
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 pulse", 32'(evt_pulse_o), 32'h0);

        // program masks computed arithmetically
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NC; i++) begin
                tm[k][i] = BW'((1 << ((k*NC+i) % BW)) | (1 << ((k*NC+i*3+2) % BW)));
                lm[k][i] = BW'((1 << ((k*NC+i) % BW)) | (1 << ((k+5*i+3) % BW)));
            end
        lm[1][3] = '0;
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NC; i++) begin
                wr(k, ad(1, i), 32'(tm[k][i]) | 32'hFF00);
                wr(k, ad(2, i), 32'(lm[k][i]));
            end
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NC; i++) begin
                rd(k, ad(1, i), v); check("R3 transmit mask readback", v, 32'(tm[k][i]));
                rd(k, ad(2, i), v); check("R4 listen mask readback", v, 32'(lm[k][i]));
            end

        // R9: enable direct, set and clear aliases
        wr(0, ad(4, 0), 32'hF);
        wr(1, ad(4, 1), 32'h5);
        wr(1, ad(4, 2), 32'h1);
        en[0] = 4'hF; en[1] = 4'h4;
        rd(0, ad(4, 0), v); check("R9 direct enable", v, 32'hF);
        rd(1, ad(4, 1), v); check("R9 set then clear alias", v, 32'h4);
        wr(1, ad(4, 1), 32'h2); en[1] = 4'h6;
        rd(1, ad(4, 2), v); check("R9 set alias keeps bits", v, 32'h6);

        // sweep every sending channel of every node
        for (int s = 0; s < NI; s++)
            for (int c = 0; c < NC; c++) begin
                e = expect_hits(tm[s][c]);
                fire(s, c, bit'(c % 2), p1, p2);
                check((c % 2) ? "R7 subscribe send pulses" : "R6 task send pulses", 32'(p1), 32'(e));
                check("R6 pulse lasts one cycle", 32'(p2), 32'h0);
                for (int k = 0; k < NI; k++) begin
                    ek = e[k*NC +: NC];
                    for (int i = 0; i < NC; i++) begin
                        rd(k, ad(3, i), v);
                        check("R4 doorbell flag", v, 32'(ek[i]));
                    end
                    rd(k, ad(4, 3), v);
                    check("R5 pending", v, 32'(en[k] & ek));
                    check("R5 irq level", 32'(irq_o[k]), 32'(|(en[k] & ek)));
                end
                clear_all();
                check("R10 clear drops irq", 32'(irq_o), 32'h0);
            end

        // R3: simultaneous sends from two nodes are ORed
        e = expect_hits(tm[0][0] | tm[1][2]);
        @(negedge clk);
        send_pulse_i[0] = 1'b1; send_pulse_i[NC+2] = 1'b1;
        @(negedge clk);
        p1 = evt_pulse_o; send_pulse_i = '0;
        check("R3 OR of two nodes", 32'(p1), 32'(e));
        clear_all();

        // R8: back-to-back sends give two pulses
        e = expect_hits(tm[0][0]);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_addr = ad(0, 0); reg_wdata = 32'h7;
        @(negedge clk);
        p1 = evt_pulse_o;
        @(negedge clk);
        p2 = evt_pulse_o; reg_wr = 1'b0;
        check("R8 first pulse", 32'(p1), 32'(e));
        check("R8 second pulse", 32'(p2), 32'(e));

        // R10: nonzero write keeps flag; set wins over simultaneous clear
        fk = 0; fi = 0;
        for (int b = NP - 1; b >= 0; b--) if (e[b]) begin fk = b / NC; fi = b % NC; end
        wr(fk, ad(3, fi), 32'h1);
        rd(fk, ad(3, fi), v); check("R10 nonzero write keeps flag", v, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'(fk); reg_addr = ad(3, fi); reg_wdata = 32'h0;
        send_pulse_i[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; send_pulse_i = '0;
        rd(fk, ad(3, fi), v); check("R10 set wins over clear", v, 32'h1);
        clear_all();

        // R2: zero write fires nothing, trigger reads zero
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_addr = ad(0, 0); reg_wdata = 32'h0;
        @(negedge clk);
        p1 = evt_pulse_o; reg_wr = 1'b0;
        check("R2 zero write no send", 32'(p1), 32'h0);
        rd(0, ad(0, 0), v); check("R2 trigger reads zero", v, 32'h0);

        // R11: out-of-range channel write
        rd(0, ad(4, 4), v); check("R11 error clear before", v, 32'h0);
        wr(0, ad(1, 5), 32'hFF);
        wr(0, ad(2, 4), 32'hFF);
        rd(0, ad(4, 4), v); check("R11 error set", v, 32'h1);
        rd(0, ad(1, 1), v); check("R11 mask ch1 untouched", v, 32'(tm[0][1]));
        rd(0, ad(2, 0), v); check("R11 mask ch0 untouched", v, 32'(lm[0][0]));
        rd(0, ad(1, 5), v); check("R11 out-of-range reads zero", v, 32'h0);
        wr(0, ad(1, 2), 32'(tm[0][2]));
        rd(0, ad(4, 4), v); check("R11 error sticky", v, 32'h1);
        rd(1, ad(4, 4), v); check("R11 other node clean", v, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule